// File: doc/BRIEF.md
# Clock Output Stop and Gating Controller

This block sits between the clock generators of a system clock synthesizer and the output pads. It receives already-generated source clocks (CPU, PCI, AGP, reference, 48 MHz and 24 MHz) and decides, per output, whether each clock toggles or is parked at a static level. The decision follows three active-low pins: CPU halt, PCI halt and power-down. It also follows a per-output enable vector and a few control bits that a register file outside the block supplies as plain inputs.

Every gating decision is resynchronized into the domain of the clock it controls. It is applied only while that clock sits at the level the output will park at, so stopping and restarting never shortens a pulse. The shared 24/48 MHz pin is fed by a break-before-make selector that never lets both sources through together. The block also drives a global pad-drive enable, and it reflects the raw halt and spread pins back as status bits.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While the CPU halt pin is low and a CPU pair is subject to it, that pair's true output sits at 0 and its complement output sits at 1.
- R2: CPU pair 0 always obeys the CPU halt pin. Pairs 1 and up obey it when `upper_cpu_free` is 0 and keep toggling when it is 1.
- R3: While the PCI halt pin is low, every stoppable PCI output sits at 0, and the free-running PCI output keeps toggling.
- R4: The AGP, reference and 48 MHz outputs keep toggling whatever the two halt pins do.
- R5: While `pwr_dn_n` is low, every output sits at 0, including the free-running ones and the CPU complements.
- R6: An output whose enable bit is 0 sits at 0, CPU complements included, and no other output is affected. Enable layout as a 20-bit vector, MSB first: cpu_t_en[2:0], cpu_c_en[2:0], pci_en[6:0], pci_free_en, agp_en[1:0], ref_en[1:0], usb_en, mux_en.
- R7: `out_mux` carries the 24 MHz source when `sel_24_48 XOR mux_pol` is 1, and the 48 MHz source otherwise.
- R8: The two selector paths feeding `out_mux` are never both open at the same time.
- R9: `pads_drive` is the inverse of `tristate_all`.
- R10: No output ever shows a high or low pulse shorter than half the period of its own source clock, including across every stop, start, enable change and selector change.
- R11: `pin_status` bit 2 follows `spread_n`, bit 1 follows `cpu_stop_n` and bit 0 follows `pci_stop_n`, combinationally.
- R12: While `rst_n` is low, all clock outputs are 0. After release with all enables set, they start toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU source clock |
| pci_clk | input | 1 | PCI source clock |
| agp_clk | input | 1 | AGP source clock |
| ref_clk | input | 1 | Reference source clock |
| clk48 | input | 1 | 48 MHz source clock |
| clk24 | input | 1 | 24 MHz source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | CPU halt pin, active low |
| pci_stop_n | input | 1 | PCI halt pin, active low |
| pwr_dn_n | input | 1 | Power-down pin, active low |
| spread_n | input | 1 | Spread-enable pin, reflected only |
| sel_24_48 | input | 1 | Shared-pin frequency select pin |
| cpu_t_en | input | N_CPU | Enable per CPU true output |
| cpu_c_en | input | N_CPU | Enable per CPU complement output |
| pci_en | input | N_PCI | Enable per stoppable PCI output |
| pci_free_en | input | 1 | Enable for the free-running PCI output |
| agp_en | input | N_AGP | Enable per AGP output |
| ref_en | input | N_REF | Enable per reference output |
| usb_en | input | 1 | Enable for the 48 MHz output |
| mux_en | input | 1 | Enable for the shared 24/48 MHz output |
| upper_cpu_free | input | 1 | 1 keeps CPU pairs 1 and up running during CPU halt |
| mux_pol | input | 1 | Inverts the meaning of `sel_24_48` |
| tristate_all | input | 1 | 1 releases all pads |
| cpu_t | output | N_CPU | CPU true outputs |
| cpu_c | output | N_CPU | CPU complement outputs |
| pci_out | output | N_PCI | Stoppable PCI outputs |
| pci_free | output | 1 | Free-running PCI output |
| agp_out | output | N_AGP | AGP outputs |
| ref_out | output | N_REF | Reference outputs |
| out48 | output | 1 | 48 MHz output |
| out_mux | output | 1 | Shared 24/48 MHz output |
| pads_drive | output | 1 | Pad drive enable |
| pin_status | output | 3 | Reflected pin levels |

## Verification
The assertions assume that each halt, power-down and enable condition stays put for several cycles of the affected domain before they look at the output. They also assume the source clocks run freely with fixed periods, so a gate change always meets a parking edge. The stimulus holds every configuration for hundreds of nanoseconds, longer than the slowest domain's synchronizer latency, before it samples. It changes inputs only between such windows, and it sweeps all sixteen combinations of the halt pins, power-down and the upper-pair free bit, plus a walking zero across every enable bit.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

  // A CPU pair parks when the halt pin is low, unless it is an upper pair
  // and the upper pairs are configured to run free.
  function automatic logic cpu_pair_halted(input int unsigned idx,
                                           input logic stop_n,
                                           input logic upper_free);
    return !stop_n && !((idx != 0) && upper_free);
  endfunction

  // Output runs when powered and enabled.
  function automatic logic plain_run(input logic pd_n, input logic en);
    return pd_n && en;
  endfunction

  // Shared pin carries the slow source when the select pin differs from polarity.
  function automatic logic pick_slow(input logic sel, input logic pol);
    return sel ^ pol;
  endfunction

endpackage

// File: rtl/clk_gate_sync.sv
module clk_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clk_gate_cell.sv
// Glitch-free gate: the pass gate changes on the falling edge (output low),
// the force-high term changes on the rising edge (output high).
module clk_gate_cell #(
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_HIGH    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_run,
  input  logic want_high,
  output logic out_clk,
  output logic live
);
  logic run_s;
  logic gate_q;
  logic high_q;

  clk_gate_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk(clk), .rst_n(rst_n), .d(want_run), .q(run_s)
  );

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= run_s;
  end

  if (HAS_HIGH) begin : g_high
    logic high_s;
    clk_gate_sync #(.STAGES(SYNC_STAGES)) u_high_sync (
      .clk(clk), .rst_n(rst_n), .d(want_high), .q(high_s)
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) high_q <= 1'b0;
      else        high_q <= high_s;
    end
  end else begin : g_nohigh
    logic unused_high;
    assign unused_high = want_high;
    assign high_q = 1'b0;
  end

  assign out_clk = (clk & gate_q) | high_q;
  assign live    = gate_q;
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int N_CPU       = 3,
  parameter int N_PCI       = 7,
  parameter int N_AGP       = 2,
  parameter int N_REF       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             cpu_clk,
  input  logic             pci_clk,
  input  logic             agp_clk,
  input  logic             ref_clk,
  input  logic             clk48,
  input  logic             clk24,
  input  logic             rst_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             pwr_dn_n,
  input  logic             spread_n,
  input  logic             sel_24_48,
  input  logic [N_CPU-1:0] cpu_t_en,
  input  logic [N_CPU-1:0] cpu_c_en,
  input  logic [N_PCI-1:0] pci_en,
  input  logic             pci_free_en,
  input  logic [N_AGP-1:0] agp_en,
  input  logic [N_REF-1:0] ref_en,
  input  logic             usb_en,
  input  logic             mux_en,
  input  logic             upper_cpu_free,
  input  logic             mux_pol,
  input  logic             tristate_all,
  output logic [N_CPU-1:0] cpu_t,
  output logic [N_CPU-1:0] cpu_c,
  output logic [N_PCI-1:0] pci_out,
  output logic             pci_free,
  output logic [N_AGP-1:0] agp_out,
  output logic [N_REF-1:0] ref_out,
  output logic             out48,
  output logic             out_mux,
  output logic             pads_drive,
  output logic [2:0]       pin_status
);
  logic cpu_clk_n;
  assign cpu_clk_n = ~cpu_clk;

  // Named events for the checker.
  logic [N_CPU-1:0] cpu_halt;
  logic             slow_pick;
  logic             live24;
  logic             live48m;
  logic             mux24_clk;
  logic             mux48_clk;

  // CPU pairs: the complement runs off the inverted source so its parking
  // level (high) is reached on its own rising edge.
  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    logic live_t;
    logic live_c;
    assign cpu_halt[i] = cpu_pair_halted(i, cpu_stop_n, upper_cpu_free);

    clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES), .HAS_HIGH(1'b0)) u_true (
      .clk(cpu_clk), .rst_n(rst_n),
      .want_run(plain_run(pwr_dn_n, cpu_t_en[i]) && !cpu_halt[i]),
      .want_high(1'b0),
      .out_clk(cpu_t[i]), .live(live_t)
    );

    clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES), .HAS_HIGH(1'b1)) u_comp (
      .clk(cpu_clk_n), .rst_n(rst_n),
      .want_run(plain_run(pwr_dn_n, cpu_c_en[i])),
      .want_high(plain_run(pwr_dn_n, cpu_c_en[i]) && cpu_halt[i]),
      .out_clk(cpu_c[i]), .live(live_c)
    );
  end

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    logic live_p;
    clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES), .HAS_HIGH(1'b0)) u_pci (
      .clk(pci_clk), .rst_n(rst_n),
      .want_run(plain_run(pwr_dn_n, pci_en[i]) && pci_stop_n),
      .want_high(1'b0),
      .out_clk(pci_out[i]), .live(live_p)
    );
  end

  logic live_pf;
  clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES), .HAS_HIGH(1'b0)) u_pci_free (
    .clk(pci_clk), .rst_n(rst_n),
    .want_run(plain_run(pwr_dn_n, pci_free_en)),
    .want_high(1'b0),
    .out_clk(pci_free), .live(live_pf)
  );

  for (genvar i = 0; i < N_AGP; i++) begin : g_agp
    logic live_a;
    clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES), .HAS_HIGH(1'b0)) u_agp (
      .clk(agp_clk), .rst_n(rst_n),
      .want_run(plain_run(pwr_dn_n, agp_en[i])),
      .want_high(1'b0),
      .out_clk(agp_out[i]), .live(live_a)
    );
  end

  for (genvar i = 0; i < N_REF; i++) begin : g_ref
    logic live_r;
    clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES), .HAS_HIGH(1'b0)) u_ref (
      .clk(ref_clk), .rst_n(rst_n),
      .want_run(plain_run(pwr_dn_n, ref_en[i])),
      .want_high(1'b0),
      .out_clk(ref_out[i]), .live(live_r)
    );
  end

  logic live_usb;
  clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES), .HAS_HIGH(1'b0)) u_usb (
    .clk(clk48), .rst_n(rst_n),
    .want_run(plain_run(pwr_dn_n, usb_en)),
    .want_high(1'b0),
    .out_clk(out48), .live(live_usb)
  );

  // Break-before-make selector: each path opens only once the other's
  // gate, seen through this path's synchronizer, has closed.
  assign slow_pick = pick_slow(sel_24_48, mux_pol);

  clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES), .HAS_HIGH(1'b0)) u_mux24 (
    .clk(clk24), .rst_n(rst_n),
    .want_run(plain_run(pwr_dn_n, mux_en) && slow_pick && !live48m),
    .want_high(1'b0),
    .out_clk(mux24_clk), .live(live24)
  );

  clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES), .HAS_HIGH(1'b0)) u_mux48 (
    .clk(clk48), .rst_n(rst_n),
    .want_run(plain_run(pwr_dn_n, mux_en) && !slow_pick && !live24),
    .want_high(1'b0),
    .out_clk(mux48_clk), .live(live48m)
  );

  assign out_mux    = mux24_clk | mux48_clk;
  assign pads_drive = ~tristate_all;
  assign pin_status = {spread_n, cpu_stop_n, pci_stop_n};
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk #(
  parameter int N_PCI       = 7,
  parameter int N_AGP       = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic             cpu_clk,
  input logic             pci_clk,
  input logic             agp_clk,
  input logic             ref_clk,
  input logic             clk48,
  input logic             rst_n,
  input logic             cpu_stop_n,
  input logic             pci_stop_n,
  input logic             pwr_dn_n,
  input logic             en_t0,
  input logic             en_c0,
  input logic             ref_en0,
  input logic             cpu_t0,
  input logic             cpu_c0,
  input logic [N_PCI-1:0] pci_out,
  input logic [N_AGP-1:0] agp_out,
  input logic             ref_out0,
  input logic             live24,
  input logic             live48m
);
  localparam int LAT = SYNC_STAGES + 3;
  localparam int CW  = $clog2(LAT + 1);
  localparam logic [CW-1:0] LAT_C = CW'(LAT);

  logic [CW-1:0] age_cpu, age_pci, age_pd, age_dis;

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) age_cpu <= '0;
    else if (!(!cpu_stop_n && pwr_dn_n && en_t0 && en_c0)) age_cpu <= '0;
    else if (age_cpu != LAT_C) age_cpu <= age_cpu + 1'b1;
  end

  always_ff @(posedge pci_clk or negedge rst_n) begin
    if (!rst_n) age_pci <= '0;
    else if (pci_stop_n) age_pci <= '0;
    else if (age_pci != LAT_C) age_pci <= age_pci + 1'b1;
  end

  always_ff @(posedge agp_clk or negedge rst_n) begin
    if (!rst_n) age_pd <= '0;
    else if (pwr_dn_n) age_pd <= '0;
    else if (age_pd != LAT_C) age_pd <= age_pd + 1'b1;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) age_dis <= '0;
    else if (ref_en0) age_dis <= '0;
    else if (age_dis != LAT_C) age_dis <= age_dis + 1'b1;
  end

  // R1: a halted pair 0 shows true low, complement high
  p_cpu_park_r1: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    (age_cpu == LAT_C) |-> (!cpu_t0 && cpu_c0));

  // R3: stoppable PCI outputs parked low
  p_pci_park_r3: assert property (@(negedge pci_clk) disable iff (!rst_n)
    (age_pci == LAT_C) |-> (pci_out == '0));

  // R5: power-down silences AGP outputs
  p_pwrdn_low_r5: assert property (@(negedge agp_clk) disable iff (!rst_n)
    (age_pd == LAT_C) |-> (agp_out == '0));

  // R6: disabled reference output held low
  p_disabled_low_r6: assert property (@(negedge ref_clk) disable iff (!rst_n)
    (age_dis == LAT_C) |-> !ref_out0);

  // R8: selector paths never open together
  p_mux_exclusive_r8: assert property (@(posedge clk48) disable iff (!rst_n)
    !(live24 && live48m));
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(
  .N_PCI(N_PCI), .N_AGP(N_AGP), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .cpu_clk(cpu_clk), .pci_clk(pci_clk), .agp_clk(agp_clk),
  .ref_clk(ref_clk), .clk48(clk48), .rst_n(rst_n),
  .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
  .en_t0(cpu_t_en[0]), .en_c0(cpu_c_en[0]), .ref_en0(ref_en[0]),
  .cpu_t0(cpu_t[0]), .cpu_c0(cpu_c[0]), .pci_out(pci_out),
  .agp_out(agp_out), .ref_out0(ref_out[0]),
  .live24(live24), .live48m(live48m)
);

// File: tb/test_clk_stop_ctrl.sv
`timescale 1ns/10ps
module test_clk_stop_ctrl;
  localparam int NC = 3, NP = 7, NA = 2, NR = 2;
  localparam int NB = 2*NC + NP + 1 + NA + NR + 2;

  logic cpu_clk = 0, pci_clk = 0, agp_clk = 0, ref_clk = 0, clk48 = 0, clk24 = 0;
  always #10   cpu_clk = ~cpu_clk;   // 50 MHz
  always #15   pci_clk = ~pci_clk;
  always #7.5  agp_clk = ~agp_clk;
  always #35   ref_clk = ~ref_clk;
  always #10.5 clk48   = ~clk48;
  always #21   clk24   = ~clk24;

  logic rst_n = 0, cpu_stop_n = 1, pci_stop_n = 1, pwr_dn_n = 1, spread_n = 1;
  logic sel_24_48 = 0, upper_cpu_free = 0, mux_pol = 0, tristate_all = 0;
  logic [NB-1:0] en = '1;

  logic [NC-1:0] cpu_t, cpu_c;
  logic [NP-1:0] pci_out;
  logic pci_free, out48, out_mux, pads_drive;
  logic [NA-1:0] agp_out;
  logic [NR-1:0] ref_out;
  logic [2:0] pin_status;

  clk_stop_ctrl i_clk_stop_ctrl (
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .agp_clk(agp_clk), .ref_clk(ref_clk),
    .clk48(clk48), .clk24(clk24), .rst_n(rst_n),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
    .spread_n(spread_n), .sel_24_48(sel_24_48),
    .cpu_t_en(en[19:17]), .cpu_c_en(en[16:14]), .pci_en(en[13:7]),
    .pci_free_en(en[6]), .agp_en(en[5:4]), .ref_en(en[3:2]),
    .usb_en(en[1]), .mux_en(en[0]),
    .upper_cpu_free(upper_cpu_free), .mux_pol(mux_pol), .tristate_all(tristate_all),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .pci_out(pci_out), .pci_free(pci_free),
    .agp_out(agp_out), .ref_out(ref_out), .out48(out48), .out_mux(out_mux),
    .pads_drive(pads_drive), .pin_status(pin_status)
  );

  logic [NB-1:0] all_out;
  assign all_out = {cpu_t, cpu_c, pci_out, pci_free, agp_out, ref_out, out48, out_mux};

  int total = 0, bad = 0;

  function automatic real half_of(input int b);
    if (b >= 14) return 10.0;
    if (b >= 6)  return 15.0;
    if (b >= 4)  return 7.5;
    if (b >= 2)  return 35.0;
    return 10.5;
  endfunction

  // Pulse-width monitor for every output (R10).
  realtime last_t [NB];
  realtime min_w  [NB];
  logic [NB-1:0] armed = '0;
  logic [NB-1:0] prev_o = '0;
  logic mon_on = 0;
  initial for (int b = 0; b < NB; b++) begin min_w[b] = 1.0e9; last_t[b] = 0; end
  always @(all_out) begin
    for (int b = 0; b < NB; b++) begin
      if (all_out[b] !== prev_o[b]) begin
        if (mon_on) begin
          if (armed[b] && ($realtime - last_t[b]) < min_w[b]) min_w[b] = $realtime - last_t[b];
          armed[b] = 1'b1;
          last_t[b] = $realtime;
        end
        prev_o[b] = all_out[b];
      end
    end
  end

  // Bench model: per output, toggle / static-high / static-low.
  function automatic logic [2*NB-1:0] expect_cls(input logic [NB-1:0] e, input logic cs,
                                                 input logic ps, input logic pd,
                                                 input logic fr);
    logic [NB-1:0] tg, hi;
    tg = '0; hi = '0;
    for (int b = 0; b < NB; b++) begin
      if (pd && e[b]) begin
        if (b >= 17) begin
          tg[b] = !( !cs && ((b - 17) == 0 || !fr) );
        end else if (b >= 14) begin
          if (!cs && ((b - 14) == 0 || !fr)) hi[b] = 1'b1; else tg[b] = 1'b1;
        end else if (b >= 7) begin
          tg[b] = ps;
        end else begin
          tg[b] = 1'b1;
        end
      end
    end
    return {tg, hi};
  endfunction

  task automatic observe(output logic [NB-1:0] s0, output logic [NB-1:0] s1,
                         output int r48, output int rmux);
    logic [NB-1:0] p;
    s0 = '0; s1 = '0; r48 = 0; rmux = 0; p = all_out;
    for (int t = 0; t < 420; t++) begin
      #1;
      s0 |= ~all_out;
      s1 |= all_out;
      if (all_out[1] && !p[1]) r48++;
      if (all_out[0] && !p[0]) rmux++;
      p = all_out;
    end
  endtask

  task automatic run_case(input logic [NB-1:0] e, input logic cs, input logic ps,
                          input logic pd, input logic fr, input string tag);
    logic [NB-1:0] s0, s1, atg, ahi;
    logic [2*NB-1:0] ex;
    int r48, rmux;
    en = e; cpu_stop_n = cs; pci_stop_n = ps; pwr_dn_n = pd; upper_cpu_free = fr;
    #400;
    observe(s0, s1, r48, rmux);
    atg = s0 & s1; ahi = s1 & ~s0;
    ex = expect_cls(e, cs, ps, pd, fr);
    total++;
    if (atg !== ex[2*NB-1:NB] || ahi !== ex[NB-1:0]) begin
      bad++;
      $display("FAIL %s cs=%b ps=%b pd=%b fr=%b en=%h: actual tog=%h hi=%h expected tog=%h hi=%h",
               tag, cs, ps, pd, fr, e, atg, ahi, ex[2*NB-1:NB], ex[NB-1:0]);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL R12 watchdog: actual=still running expected=finished");
    finish_run();
  end

  initial begin
    logic [NB-1:0] s0, s1;
    int r48, rmux;
    #0.25;
    #100;
    // R12: reset state
    total++;
    if (all_out !== '0) begin
      bad++; $display("FAIL R12 reset outputs: actual=%h expected=%h", all_out, {NB{1'b0}});
    end
    rst_n = 1;
    #300;
    mon_on = 1;
    run_case('1, 1, 1, 1, 0, "R12 start after reset");

    // R1 R2 R3 R4 R5: all pin and free-bit combinations
    for (int k = 0; k < 16; k++)
      run_case('1, k[0], k[1], k[2], k[3], "R1 R2 R3 R4 R5 pin sweep");

    // R6: walking zero over every enable bit
    for (int b = 0; b < NB; b++) begin
      logic [NB-1:0] e;
      e = '1; e[b] = 1'b0;
      run_case(e, 1, 1, 1, 0, "R6 walking disable");
    end
    begin
      logic [NB-1:0] e;
      e = '1; e[14] = 1'b0;
      run_case(e, 0, 1, 1, 0, "R6 R1 disabled complement under halt");
    end

    // R7: shared pin source selection
    en = '1; cpu_stop_n = 1; pci_stop_n = 1; pwr_dn_n = 1;
    for (int k = 0; k < 4; k++) begin
      logic want_slow, got_slow;
      sel_24_48 = k[0]; mux_pol = k[1];
      want_slow = (k[0] == 1 && k[1] == 0) || (k[0] == 0 && k[1] == 1);
      #400;
      observe(s0, s1, r48, rmux);
      got_slow = (rmux * 3 < r48 * 2);
      total++;
      if (got_slow !== want_slow || rmux == 0) begin
        bad++;
        $display("FAIL R7 sel=%b pol=%b: actual slow=%b (rises %0d vs %0d) expected slow=%b",
                 k[0], k[1], got_slow, rmux, r48, want_slow);
      end
    end

    // R9: pad drive
    for (int k = 0; k < 2; k++) begin
      tristate_all = k[0];
      #1;
      total++;
      if (pads_drive !== !k[0]) begin
        bad++; $display("FAIL R9 tristate=%b: actual=%b expected=%b", k[0], pads_drive, !k[0]);
      end
    end
    tristate_all = 0;

    // R11: reflected pins
    for (int k = 0; k < 8; k++) begin
      spread_n = k[2]; cpu_stop_n = k[1]; pci_stop_n = k[0];
      #1;
      total++;
      if (pin_status !== k[2:0]) begin
        bad++; $display("FAIL R11 status: actual=%b expected=%b", pin_status, k[2:0]);
      end
    end
    spread_n = 1; cpu_stop_n = 1; pci_stop_n = 1;
    #400;

    // R10 R8: no short pulse anywhere, shared pin included
    mon_on = 0;
    for (int b = 0; b < NB; b++) begin
      total++;
      if (min_w[b] < half_of(b) - 0.05) begin
        bad++;
        $display("FAIL R10 output bit %0d: actual min pulse=%0.2f expected>=%0.2f",
                 b, min_w[b], half_of(b));
      end
    end
    finish_run();
  end
endmodule